// File: doc/BRIEF.md
# Drain-Source Short Fault Monitor

This block watches the drain-source comparators of a three-phase bridge of six external switches. Each comparator reports that the voltage across its switch is above the fault threshold. The block also receives the six gate-on commands from the control logic. A comparator result counts only while its switch is commanded on and its turn-on blanking window has run out. The window lasts the dead time plus an extra settling delay, counted in clock cycles, and it restarts on every turn-on edge of that switch.

A qualified result on a high-side switch means the phase is shorted to ground. A qualified result on a low-side switch means it is shorted to supply. When a high-side and a low-side result qualify in the same cycle, the block reports a shorted load. The stop-on-fault input selects the reaction:
- **High:** the flags are captured and a disable request is raised for all gate outputs. Both are held until a clear pulse or a completed serial register read.
- **Low:** the flags follow the live comparators one cycle later, and no disable request is raised.

In both modes every qualified fault sets a sticky per-switch bit in the fault register. Those bits are cleared only by a clear.

The trip controller is a state machine with two states:
- **TRIP_RUN:** normal operation, no disable request.
- **TRIP_HOLD:** the disable request is active.

Its transitions are:
- **arm_trip:** TRIP_RUN to TRIP_HOLD, taken when stop-on-fault is high, a fault qualifies and no clear is present.
- **release:** TRIP_HOLD to TRIP_RUN, taken on a clear pulse or a read-done pulse.
- **hold / idle:** the self-loops of TRIP_HOLD and TRIP_RUN.

Top module: `ds_short_monitor`

## Requirements
- R1: A comparator result has no effect on any output while its gate-on bit is low.
- R2: After a gate-on bit rises, its comparator is ignored for BLANK = DEAD_CYC + EXTRA_CYC cycles (8 by default). The result first counts in the cycle BLANK clock edges after the first edge that samples the gate high. Turning the switch off and on again restarts the window.
- R3: Gate-on and comparator bits 0..2 are high-side switches and bits 3..5 are low-side switches. A qualified high-side fault drives `flag_gnd`, and a qualified low-side fault drives `flag_sup`. Each flag is registered, so it appears one edge after the fault qualifies.
- R4: `load_short` rises when a high-side and a low-side fault qualify in the same cycle.
- R5: With `stop_en` high, a qualified fault sets `drv_disable` and holds the flags until a clear, even after the comparators fall.
- R6: With `stop_en` low, `drv_disable` stays low and the flags follow the live qualified faults with a delay of one edge.
- R7: Each qualified fault sets the `fault_reg` bit with the same index as the switch, in either mode. The bit stays set until a clear.
- R8: A `clr_pulse` or `rd_done` high at an edge clears `fault_reg`, the flags and `drv_disable` at that edge. A clear takes priority over a fault in the same cycle.
- R9: When several faults are active, each flag is the OR of the flag patterns of all of them.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_pulse | input | 1 | Synchronous clear of all latched state |
| rd_done | input | 1 | Serial fault register read completed; clears like clr_pulse |
| stop_en | input | 1 | 1: latch and disable on a short; 0: live flags only |
| gate_on | input | 6 | Gate-on commands, [2:0] high side, [5:3] low side |
| vds_over | input | 6 | Comparator results, same indexing as gate_on |
| flag_gnd | output | 1 | Short-to-ground flag |
| flag_sup | output | 1 | Short-to-supply flag |
| load_short | output | 1 | Shorted-load indication |
| drv_disable | output | 1 | Request to turn off all gate outputs |
| fault_reg | output | 6 | Sticky per-switch short bits |

## Verification
The assertions take for granted that `gate_on` and `vds_over` change only between clock edges. They also assume that the clear inputs are single synchronous pulses, with no expectation of how long a fault persists. The stimulus drives every input one time unit after a rising edge and holds it for whole cycles. Clears are issued as one-cycle pulses, either while faults persist or after they have been removed. This exercises both the clear-priority ordering and the recovery path.

// File: rtl/ds_mon_pkg.sv
package ds_mon_pkg;

    typedef enum logic {
        TRIP_RUN  = 1'b0,
        TRIP_HOLD = 1'b1
    } trip_state_e;

    typedef struct packed {
        logic load;
        logic sup;
        logic gnd;
    } flag_pat_t;

endpackage

// File: rtl/ds_blank_chan.sv
module ds_blank_chan #(
    parameter int unsigned BLANK_CYC = 8,
    parameter int unsigned CNT_W     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_on,
    input  logic vds_over,
    output logic qual_o
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BLANK_CYC - 1);

    logic             gate_q;
    logic [CNT_W-1:0] cnt;
    logic             rise;
    logic             blanked;

    assign rise    = gate_on & ~gate_q;
    assign blanked = ~gate_on | rise | (cnt != '0);
    assign qual_o  = vds_over & ~blanked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            cnt    <= '0;
        end else begin
            gate_q <= gate_on;
            if (rise)
                cnt <= LOAD_VAL;
            else if (!gate_on)
                cnt <= '0;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    // R1: switch off means no qualified result
    assert_off_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_on |-> !qual_o);

    // R2: the edge that first sees the gate high is always blanked
    assert_turnon_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on) |-> !qual_o);

endmodule

// File: rtl/ds_trip_fsm.sv
module ds_trip_fsm
    import ds_mon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      stop_en,
    input  flag_pat_t live,
    output flag_pat_t flags,
    output logic      disable_o
);
    trip_state_e state, state_nxt;
    flag_pat_t   lat_pat;
    flag_pat_t   live_q;
    logic        any_live;

    assign any_live = live.gnd | live.sup;

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            TRIP_RUN:  if (!clr && stop_en && any_live) state_nxt = TRIP_HOLD;
            TRIP_HOLD: if (clr) state_nxt = TRIP_RUN;
            default:   state_nxt = TRIP_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TRIP_RUN;
        else        state <= state_nxt;
    end

    // flag capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_pat <= '0;
            live_q  <= '0;
        end else if (clr) begin
            lat_pat <= '0;
            live_q  <= '0;
        end else begin
            live_q <= live;
            if (stop_en) lat_pat <= lat_pat | live;
        end
    end

    // outputs
    always_comb begin
        flags = lat_pat | live_q;
        unique case (state)
            TRIP_RUN:  disable_o = 1'b0;
            TRIP_HOLD: disable_o = 1'b1;
            default:   disable_o = 1'b0;
        endcase
    end

    assert_trip_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_en && any_live && !clr) |=> disable_o);

    assert_trip_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (disable_o && !clr) |=> disable_o);

    assert_live_no_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!disable_o && !stop_en) |=> !disable_o);

    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!disable_o && flags == '0));

endmodule

// File: rtl/ds_sticky_reg.sv
module ds_sticky_reg #(
    parameter int unsigned N_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [N_BITS-1:0] set,
    output logic [N_BITS-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else          q <= q | set;
    end

    // R7: no bit falls without a clear
    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((q & $past(q)) == $past(q)));

    // R7: a set bit appears at the next edge
    assert_sticky_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && set != '0) |=> ((q & $past(set)) == $past(set)));

endmodule

// File: rtl/ds_short_monitor.sv
module ds_short_monitor
    import ds_mon_pkg::*;
#(
    parameter int unsigned N_PH      = 3,
    parameter int unsigned DEAD_CYC  = 3,
    parameter int unsigned EXTRA_CYC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_pulse,
    input  logic            rd_done,
    input  logic            stop_en,
    input  logic [2*N_PH-1:0] gate_on,
    input  logic [2*N_PH-1:0] vds_over,
    output logic            flag_gnd,
    output logic            flag_sup,
    output logic            load_short,
    output logic            drv_disable,
    output logic [2*N_PH-1:0] fault_reg
);
    localparam int unsigned N_SW      = 2 * N_PH;
    localparam int unsigned BLANK_CYC = DEAD_CYC + EXTRA_CYC;
    localparam int unsigned CNT_W     = $clog2(BLANK_CYC + 1);

    logic [N_SW-1:0] qual;
    logic            clr;
    flag_pat_t       live;
    flag_pat_t       flags;

    assign clr = clr_pulse | rd_done;

    for (genvar i = 0; i < N_SW; i++) begin : g_chan
        ds_blank_chan #(
            .BLANK_CYC (BLANK_CYC),
            .CNT_W     (CNT_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .gate_on  (gate_on[i]),
            .vds_over (vds_over[i]),
            .qual_o   (qual[i])
        );
    end

    always_comb begin
        live.gnd  = |qual[N_PH-1:0];
        live.sup  = |qual[N_SW-1:N_PH];
        live.load = live.gnd & live.sup;
    end

    ds_trip_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .stop_en   (stop_en),
        .live      (live),
        .flags     (flags),
        .disable_o (drv_disable)
    );

    ds_sticky_reg #(
        .N_BITS (N_SW)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .set   (qual),
        .q     (fault_reg)
    );

    assign flag_gnd   = flags.gnd;
    assign flag_sup   = flags.sup;
    assign load_short = flags.load;

endmodule

// File: tb/ds_short_monitor_bench.sv
`timescale 1ns/100ps
module ds_short_monitor_bench;
    localparam int BLANK = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_pulse = 1'b0;
    logic       rd_done = 1'b0;
    logic       stop_en = 1'b0;
    logic [5:0] gate_on = '0;
    logic [5:0] vds_over = '0;
    logic       flag_gnd, flag_sup, load_short, drv_disable;
    logic [5:0] fault_reg;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ds_short_monitor u_ds_short_monitor (
        .clk(clk), .rst_n(rst_n), .clr_pulse(clr_pulse), .rd_done(rd_done),
        .stop_en(stop_en), .gate_on(gate_on), .vds_over(vds_over),
        .flag_gnd(flag_gnd), .flag_sup(flag_sup), .load_short(load_short),
        .drv_disable(drv_disable), .fault_reg(fault_reg)
    );

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] outs();
        return {23'd0, drv_disable, load_short, flag_sup, flag_gnd, fault_reg};
    endfunction

    task automatic clear_all();
        gate_on = '0; vds_over = '0;
        clr_pulse = 1'b1; step(1); clr_pulse = 1'b0; step(1);
    endtask

    task automatic t_reset();
        step(2);
        chk("R10 reset outputs", outs(), 32'd0);
        rst_n = 1'b1; step(1);
    endtask

    task automatic t_off_ignored();
        stop_en = 1'b1; gate_on = '0; vds_over = 6'h3f;
        step(20);
        chk("R1 off switch ignored", outs(), 32'd0);
        clear_all();
    endtask

    task automatic t_blank_live();
        stop_en = 1'b0; gate_on = 6'b000001; vds_over = 6'b000001;
        step(BLANK);
        chk("R2 still blanked", {31'd0, flag_gnd}, 32'd0);
        step(1);
        chk("R3 hs fault sets flag_gnd", {30'd0, flag_sup, flag_gnd}, 32'd1);
        chk("R7 sticky bit 0", {26'd0, fault_reg}, 32'h01);
        chk("R6 no disable in live mode", {31'd0, drv_disable}, 32'd0);
        vds_over = '0; step(1);
        chk("R6 flag follows live", {31'd0, flag_gnd}, 32'd0);
        chk("R7 bit stays", {26'd0, fault_reg}, 32'h01);
        clear_all();
    endtask

    task automatic t_restart();
        stop_en = 1'b0; gate_on = 6'b000010; step(5);
        gate_on = '0; step(1);
        gate_on = 6'b000010; vds_over = 6'b000010;
        step(BLANK);
        chk("R2 window restarted", {26'd0, fault_reg}, 32'd0);
        step(1);
        chk("R2 counts after restart", {26'd0, fault_reg}, 32'h02);
        clear_all();
    endtask

    task automatic t_latch();
        stop_en = 1'b1; gate_on = 6'b010000; vds_over = 6'b010000;
        step(BLANK + 1);
        chk("R5 latch sup+disable", {29'd0, drv_disable, flag_sup, flag_gnd}, 32'b110);
        vds_over = '0; gate_on = '0; step(4);
        chk("R5 held after fault gone", {29'd0, drv_disable, flag_sup, flag_gnd}, 32'b110);
        chk("R7 sticky bit 4", {26'd0, fault_reg}, 32'h10);
        rd_done = 1'b1; step(1); rd_done = 1'b0;
        chk("R8 read-done clears", outs(), 32'd0);
        step(1);
    endtask

    task automatic t_load();
        stop_en = 1'b0; gate_on = 6'b001010; vds_over = 6'b001010;
        step(BLANK + 1);
        chk("R4 load short", {31'd0, load_short}, 32'd1);
        chk("R9 both flags", {30'd0, flag_sup, flag_gnd}, 32'b11);
        chk("R7 bits 1 and 3", {26'd0, fault_reg}, 32'h0a);
        clear_all();
    endtask

    task automatic t_clear_priority();
        stop_en = 1'b1; gate_on = 6'b000100; vds_over = 6'b000100;
        step(BLANK + 1);
        chk("R5 tripped", {31'd0, drv_disable}, 32'd1);
        clr_pulse = 1'b1; step(1); clr_pulse = 1'b0;
        chk("R8 clear wins", outs(), 32'd0);
        step(1);
        chk("R5 retrip on persisting fault", {31'd0, drv_disable}, 32'd1);
        clear_all();
    endtask

    logic done = 1'b0;

    initial begin
        t_reset();
        t_off_ignored();
        t_blank_live();
        t_restart();
        t_latch();
        t_load();
        t_clear_priority();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule